// File: doc/BRIEF.md
# Converter Light-Load Mode Selector

This block decides, once per switching cycle, whether a synchronous buck converter runs in fixed-frequency PWM or in hysteretic pulse-frequency mode. A comparator reports the polarity of the switch node while the low-side transistor conducts. A strobe, timed just before the high-side turn-on, marks the cycle in which that polarity is valid. A negative reading means the inductor current is still continuous and favours PWM. A positive reading means current is flowing back through the low side and favours hysteretic mode.

The mode only changes after a run of identical readings, so that the converter does not chatter near the boundary. Three inputs can force PWM. A permit pin that forbids hysteretic operation while low, a flag raised during reference slewing (start-up ramp, voltage-code change, or a switch between the analog set-point and the code), and a comparator that reports a load step dropping the output below the hysteretic regulation floor. In hysteretic mode the block also issues the high-side pulse request from two window comparators. All inputs and outputs are plain level signals. There is no data stream and no handshake.

Top module: `lite_load_mode_sel`

## Requirements
- R1: After reset the mode output is 0 (PWM) and the pulse request is 0.
- R2: In PWM, a strobed sample with `sw_pos`=1 that completes a run of 8 consecutive positive strobed samples sets `mode_hyst` to 1 on the clock edge that captures it. Fewer than 8 leave the mode at PWM.
- R3: In hysteretic mode, a strobed sample with `sw_pos`=0 that completes a run of 8 consecutive negative strobed samples returns `mode_hyst` to 0 on the capturing edge.
- R4: A strobed sample whose polarity opposes the pending change empties the run. A further full run of 8 is then needed.
- R5: Cycles with `strobe`=0 neither add to a run nor break it.
- R6: While `hyst_permit`=0, the mode is 0 from the next edge on. Strobed samples taken then do not count, and a fresh run of 8 is required once the permit returns.
- R7: While `ref_slewing`=1, the mode is held at PWM in the same way as R6, and any partial run is discarded.
- R8: In hysteretic mode, `below_floor`=1 returns the mode to PWM on the next edge, whatever the samples say.
- R9: In hysteretic mode, `pfm_req` becomes 1 on the edge after `below_low`=1 and becomes 0 on the edge after `above_high`=1 (with `below_low`=0). Otherwise it holds. If both flags are high, setting wins.
- R10: `pfm_req` is 0 whenever `mode_hyst` is 0, including in the cycle in which the mode has just left hysteretic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe | input | 1 | Polarity sample valid this cycle |
| sw_pos | input | 1 | Switch node positive during low-side conduction (1) or negative (0) |
| hyst_permit | input | 1 | 1 allows hysteretic mode, 0 forces PWM |
| ref_slewing | input | 1 | Reference is ramping or switching source, so PWM is held |
| below_floor | input | 1 | Output below the hysteretic regulation floor |
| below_low | input | 1 | Output below the lower hysteretic threshold |
| above_high | input | 1 | Output above the upper hysteretic threshold |
| mode_hyst | output | 1 | 0 = PWM, 1 = hysteretic |
| pfm_req | output | 1 | High-side pulse request in hysteretic mode |

## Verification
Every cycle, the assertions check that a forcing input (permit low, slewing, floor breach) leaves the mode at PWM one edge later. They also check that the request is never high in PWM, that an entry into hysteretic mode is always preceded by a strobed positive sample, and that unstrobed cycles leave the run length alone. Only the bench scenarios can show the exact count of eight: that seven samples fall short, that a mismatch or a forced-PWM pulse in mid-run costs a full fresh run, and that the request's set and clear follow the window flags. A seeded random phase, with long runs of one polarity, stresses all of these together.

// File: rtl/lite_load_mode_pkg.sv
package lite_load_mode_pkg;
  typedef enum logic {
    MODE_PWM  = 1'b0,
    MODE_HYST = 1'b1
  } conv_mode_e;
endpackage

// File: rtl/lite_load_run_cnt.sv
// Counts consecutive strobed samples that agree with the pending mode change.
module lite_load_run_cnt #(
  parameter int RUN_LEN = 8,
  localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic agree,
  input  logic restart,
  output logic run_done
);
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign run_done = strobe && agree && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart)   cnt_q <= '0;
    else if (strobe)    cnt_q <= agree ? cnt_q + 1'b1 : '0;
  end

  // Cycles without a strobe leave the run untouched
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !restart) |=> $stable(cnt_q));

  // A disagreeing sample empties the run
  assert_mismatch_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !agree) |=> (cnt_q == '0));
endmodule

// File: rtl/lite_load_mode_fsm.sv
// Holds the operating mode and applies the forcing conditions.
module lite_load_mode_fsm
  import lite_load_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_done,
  input  logic       force_pwm,
  input  logic       below_floor,
  input  logic       strobe,
  input  logic       sw_pos,
  output conv_mode_e mode_q,
  output conv_mode_e mode_nxt,
  output logic       restart
);
  always_comb begin
    mode_nxt = mode_q;
    if (force_pwm)                                 mode_nxt = MODE_PWM;
    else if (mode_q == MODE_HYST && below_floor)   mode_nxt = MODE_PWM;
    else if (run_done)
      mode_nxt = (mode_q == MODE_PWM) ? MODE_HYST : MODE_PWM;
  end

  assign restart = force_pwm || (mode_nxt != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_PWM;
    else        mode_q <= mode_nxt;
  end

  assert_force_pwm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_pwm |=> (mode_q == MODE_PWM));

  assert_floor_escape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HYST && below_floor) |=> (mode_q == MODE_PWM));

  assert_enter_needs_pos_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HYST && $past(mode_q) == MODE_PWM) |-> $past(strobe && sw_pos));

  assert_leave_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PWM && $past(mode_q) == MODE_HYST)
      |-> $past(force_pwm || below_floor || (strobe && !sw_pos)));
endmodule

// File: rtl/lite_load_pfm_req.sv
// High-side pulse request for hysteretic operation.
module lite_load_pfm_req
  import lite_load_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  conv_mode_e mode_nxt,
  input  logic       below_low,
  input  logic       above_high,
  output logic       req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     req_q <= 1'b0;
    else if (mode_nxt != MODE_HYST) req_q <= 1'b0;
    else if (below_low)             req_q <= 1'b1;
    else if (above_high)            req_q <= 1'b0;
  end

  assert_req_set_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(below_low));

  assert_req_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !below_low && above_high) |=> !req_q);
endmodule

// File: rtl/lite_load_mode_sel.sv
module lite_load_mode_sel
  import lite_load_mode_pkg::*;
#(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic sw_pos,
  input  logic hyst_permit,
  input  logic ref_slewing,
  input  logic below_floor,
  input  logic below_low,
  input  logic above_high,
  output logic mode_hyst,
  output logic pfm_req
);
  conv_mode_e mode_q, mode_nxt;
  logic       run_done, restart, agree, force_pwm;

  assign force_pwm = !hyst_permit || ref_slewing;
  // PWM waits for positive samples, hysteretic waits for negative ones
  assign agree     = (mode_q == MODE_PWM) ? sw_pos : !sw_pos;

  lite_load_run_cnt #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .agree(agree),
    .restart(restart), .run_done(run_done)
  );

  lite_load_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .run_done(run_done), .force_pwm(force_pwm),
    .below_floor(below_floor), .strobe(strobe), .sw_pos(sw_pos),
    .mode_q(mode_q), .mode_nxt(mode_nxt), .restart(restart)
  );

  lite_load_pfm_req u_req (
    .clk(clk), .rst_n(rst_n), .mode_nxt(mode_nxt),
    .below_low(below_low), .above_high(above_high), .req_q(pfm_req)
  );

  assign mode_hyst = (mode_q == MODE_HYST);

  assert_no_req_in_pwm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_hyst |-> !pfm_req);

  assert_slew_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_slewing |=> !mode_hyst);
endmodule

// File: tb/lite_load_mode_sel_tb.sv
`timescale 1ns/1ps
module lite_load_mode_sel_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 0, sw_pos = 0, hyst_permit = 1, ref_slewing = 0;
  logic below_floor = 0, below_low = 0, above_high = 0;
  logic mode_hyst, pfm_req;

  int checks = 0, failures = 0;
  bit done = 0;
  bit e_mode = 0, e_req = 0;
  int e_cnt = 0;

  always #2.5 clk = ~clk;

  lite_load_mode_sel u_dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .sw_pos(sw_pos),
    .hyst_permit(hyst_permit), .ref_slewing(ref_slewing),
    .below_floor(below_floor), .below_low(below_low), .above_high(above_high),
    .mode_hyst(mode_hyst), .pfm_req(pfm_req)
  );

  // Expected next mode from the requirements (R2..R8)
  function automatic bit next_mode(bit m, int c, bit stb, bit sw, bit perm,
                                   bit slew, bit flr);
    if (!perm || slew) return 1'b0;
    if (m && flr) return 1'b0;
    if (stb && (sw == !m) && c == 7) return !m;
    return m;
  endfunction

  function automatic bit next_req(bit nm, bit r, bit lo, bit hi);
    if (!nm) return 1'b0;
    if (lo) return 1'b1;
    if (hi) return 1'b0;
    return r;
  endfunction

  task automatic check(string tag);
    checks++;
    if (mode_hyst !== e_mode) begin
      failures++;
      $display("FAIL %s mode_hyst actual=%0b expected=%0b", tag, mode_hyst, e_mode);
    end
    checks++;
    if (pfm_req !== e_req) begin
      failures++;
      $display("FAIL %s pfm_req actual=%0b expected=%0b", tag, pfm_req, e_req);
    end
  endtask

  task automatic step(bit stb, bit sw, bit perm, bit slew, bit flr,
                      bit lo, bit hi, string tag);
    bit nm;
    @(negedge clk);
    strobe = stb; sw_pos = sw; hyst_permit = perm; ref_slewing = slew;
    below_floor = flr; below_low = lo; above_high = hi;
    @(posedge clk);
    nm = next_mode(e_mode, e_cnt, stb, sw, perm, slew, flr);
    if (nm != e_mode || !perm || slew) e_cnt = 0;
    else if (stb) e_cnt = (sw == !e_mode) ? e_cnt + 1 : 0;
    e_req = next_req(nm, e_req, lo, hi);
    e_mode = nm;
    #1 check(tag);
  endtask

  task automatic samples(int n, bit sw, string tag);
    for (int i = 0; i < n; i++) begin
      step(1, sw, 1, 0, 0, 0, 0, tag);
      step(0, !sw, 1, 0, 0, 0, 0, {tag, "_R5"});  // unstrobed opposite polarity
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit regime;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 check("R1_reset");
    @(negedge clk) rst_n = 1'b1;
    #1 check("R1_after_release");

    samples(7, 1, "R2_seven_short");          // still PWM
    samples(1, 1, "R2_eighth_enters");        // hysteretic now
    step(0, 0, 1, 0, 0, 1, 0, "R9_set");
    step(0, 0, 1, 0, 0, 0, 0, "R9_hold");
    step(0, 0, 1, 0, 0, 0, 1, "R9_clear");
    step(0, 0, 1, 0, 0, 1, 1, "R9_both_set_wins");
    samples(5, 0, "R4_partial");
    samples(1, 1, "R4_mismatch");
    samples(7, 0, "R4_seven_after_clear");
    samples(1, 0, "R3_eighth_leaves_R10");

    samples(8, 1, "R2_reenter");
    step(0, 0, 1, 0, 0, 1, 0, "R9_set2");
    step(0, 0, 1, 0, 1, 0, 0, "R8_floor_escape_R10");

    samples(8, 1, "R2_reenter2");
    step(0, 0, 0, 0, 0, 1, 0, "R6_permit_low");
    for (int i = 0; i < 10; i++) step(1, 1, 0, 0, 0, 0, 0, "R6_blocked");
    samples(7, 1, "R6_fresh_run_short");
    samples(1, 1, "R6_fresh_run_done");
    step(0, 0, 1, 1, 0, 0, 0, "R7_slew_leaves");
    samples(5, 1, "R7_partial");
    step(0, 0, 1, 1, 0, 0, 0, "R7_pulse");
    samples(3, 1, "R7_partial_lost");
    samples(5, 1, "R7_fresh_run");

    regime = 0;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(63) == 0) regime = !regime;
      step($urandom_range(2) == 0,
           ($urandom_range(19) == 0) ? !regime : regime,
           $urandom_range(59) != 0, $urandom_range(79) == 0,
           $urandom_range(39) == 0, $urandom_range(7) == 0,
           $urandom_range(7) == 0, "R2_R3_R9_random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule